// File: doc/BRIEF.md
# LAPD Receive Address Filter

This block decides whether an incoming LAPD frame is meant for this station. It watches a byte stream that has already been stripped of flags and stuffing bits. The first byte of a frame is the SAPI octet and the second is the TEI octet. Once it has both, it gives a one-cycle verdict strobe and a held accept or reject flag.

The filter holds a set of programmable SAPI and TEI values, set by `N_PAIRS`, which defaults to two. A programmable SAPI value is paired with the programmable TEI value of the same index. One SAPI mask and one TEI mask apply to every programmable comparison. The broadcast management SAPI (octet 0xFE or 0xFC) and the TEI-assignment group TEI (octet 0xFF) are fixed. They are always compared exactly, whatever the masks hold.

A frame is accepted for these address pairs:
- a programmable SAPI with its own TEI or with the group TEI;
- the group SAPI with any programmable TEI or with the group TEI.

Pairs that cross indices are refused. Software loads the compare values through a simple write port.

Top module: `lapd_addr_filter`

## Requirements
- R1: A write with `cfg_we` high loads `cfg_wdata` into the register selected by `cfg_addr` at the next rising edge. The register indices are:
  - 0 to `N_PAIRS`-1: the SAPI values;
  - `N_PAIRS` to 2·`N_PAIRS`-1: the TEI values;
  - 2·`N_PAIRS`: the SAPI mask;
  - 2·`N_PAIRS`+1: the TEI mask.

  Any other index changes nothing. All registers reset to 0x00.
- R2: `verdict_valid` is high for exactly the one cycle after the rising edge that takes in the TEI octet. The TEI octet is the first valid byte without `rx_sof` after a start byte.
- R3: A frame is accepted when SAPI value i and TEI value i both match, for some index i.
- R4: A frame whose SAPI matches only value i and whose TEI matches only value j, with j different from i, is rejected.
- R5: A SAPI octet of exactly 0xFE or 0xFC is the group SAPI. It pairs with any programmable TEI match or with the group TEI.
- R6: A TEI octet of exactly 0xFF is the group TEI. It pairs with any programmable SAPI match or with the group SAPI.
- R7: A mask bit of 1 removes that bit position from the programmable comparisons. A mask bit of 0 requires equality.
- R8: The masks never widen the group comparisons. An octet that differs from 0xFE, 0xFC or 0xFF counts as a group value only if it matches a programmable value.
- R9: A frame that ends before its TEI octet arrives gives a verdict strobe with accept low, one cycle after the end.
  - The frame ends when `rx_eof` is high with no valid byte while waiting for the TEI.
  - It also ends when the start byte itself carries `rx_eof`.
- R10: `verdict_accept` changes only together with `verdict_valid`. It holds between verdicts and resets to 0.
- R11: Bytes after the TEI octet, and valid bytes outside a frame, create no verdict. A new `rx_sof` byte always restarts address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | `rx_data` holds a received byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | Frame has ended (with or without a byte) |
| rx_data | input | 8 | Received byte |
| verdict_valid | output | 1 | One-cycle strobe: address verdict ready |
| verdict_accept | output | 1 | Verdict: 1 accept, 0 reject; held between strobes |

## Verification
A stuck or wrongly latched SAPI octet shows up at the first verdict strobe of the next frame, as an accept where a reject was due or the reverse. A sequencer that gets the wrong phase shows up as a strobe on the wrong cycle or a missing strobe. The bench samples every frame one cycle after its TEI octet, so such a fault is caught within one frame. A broken mask or group path only shows when the SAPI or TEI octet lands near a group value or on a masked bit. The directed cases place octets exactly there, and the random frames draw octets from the programmed values with single bits flipped.

// File: rtl/lapd_af_pkg.sv
package lapd_af_pkg;
   localparam int OCT_W = 8;
   localparam int N_GRP_SAPI = 2;
   localparam logic [N_GRP_SAPI-1:0][OCT_W-1:0] GRP_SAPI_VALS = {8'hFC, 8'hFE};
   localparam logic [OCT_W-1:0] GRP_TEI_VAL = 8'hFF;

   typedef enum logic {
      ST_IDLE,
      ST_WANT_TEI
   } af_state_e;
endpackage

// File: rtl/lapd_af_regs.sv
module lapd_af_regs #(
   parameter int N_PAIRS = 2,
   parameter int W       = 8,
   parameter int AW      = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [AW-1:0]               addr,
   input  logic [W-1:0]                wdata,
   output logic [N_PAIRS-1:0][W-1:0]   sapi_ref,
   output logic [N_PAIRS-1:0][W-1:0]   tei_ref,
   output logic [W-1:0]                sapi_mask,
   output logic [W-1:0]                tei_mask
);
   localparam int SMASK_IDX = 2 * N_PAIRS;
   localparam int TMASK_IDX = 2 * N_PAIRS + 1;

   for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              sapi_ref[i] <= '0;
         else if (we && addr == AW'(i))           sapi_ref[i] <= wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              tei_ref[i] <= '0;
         else if (we && addr == AW'(N_PAIRS + i)) tei_ref[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            sapi_mask <= '0;
      else if (we && addr == AW'(SMASK_IDX)) sapi_mask <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tei_mask <= '0;
      else if (we && addr == AW'(TMASK_IDX)) tei_mask <= wdata;
   end

   // R10-style hold on the masks: no write, no change
   p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(sapi_mask) && $stable(tei_mask));
endmodule

// File: rtl/lapd_af_match.sv
module lapd_af_match #(
   parameter int W        = 8,
   parameter bit USE_MASK = 1'b1
) (
   input  logic [W-1:0] data,
   input  logic [W-1:0] ref_val,
   input  logic [W-1:0] mask,
   output logic         hit
);
   logic [W-1:0] eff_mask;
   assign eff_mask = mask & {W{USE_MASK}};
   assign hit      = ((data ^ ref_val) & ~eff_mask) == '0;
endmodule

// File: rtl/lapd_af_decide.sv
module lapd_af_decide
   import lapd_af_pkg::*;
#(
   parameter int N_PAIRS = 2,
   parameter int W       = 8
) (
   input  logic [W-1:0]                sapi_oct,
   input  logic [W-1:0]                tei_oct,
   input  logic [N_PAIRS-1:0][W-1:0]   sapi_ref,
   input  logic [N_PAIRS-1:0][W-1:0]   tei_ref,
   input  logic [W-1:0]                sapi_mask,
   input  logic [W-1:0]                tei_mask,
   output logic                        any_sapi_hit,
   output logic                        any_tei_hit,
   output logic                        accept
);
   logic [N_PAIRS-1:0]    s_hit, t_hit, pair_ok;
   logic [N_GRP_SAPI-1:0] sg_hit;
   logic                  sapi_grp, tei_grp;

   for (genvar i = 0; i < N_PAIRS; i++) begin : g_prog
      lapd_af_match #(.W(W), .USE_MASK(1'b1)) u_s (
         .data(sapi_oct), .ref_val(sapi_ref[i]), .mask(sapi_mask), .hit(s_hit[i]));
      lapd_af_match #(.W(W), .USE_MASK(1'b1)) u_t (
         .data(tei_oct), .ref_val(tei_ref[i]), .mask(tei_mask), .hit(t_hit[i]));
      assign pair_ok[i] = s_hit[i] & (t_hit[i] | tei_grp);
   end

   for (genvar g = 0; g < N_GRP_SAPI; g++) begin : g_grp_sapi
      lapd_af_match #(.W(W), .USE_MASK(1'b0)) u_g (
         .data(sapi_oct), .ref_val(W'(GRP_SAPI_VALS[g])), .mask(sapi_mask), .hit(sg_hit[g]));
   end

   lapd_af_match #(.W(W), .USE_MASK(1'b0)) u_grp_tei (
      .data(tei_oct), .ref_val(W'(GRP_TEI_VAL)), .mask(tei_mask), .hit(tei_grp));

   assign sapi_grp     = |sg_hit;
   assign any_sapi_hit = (|s_hit) | sapi_grp;
   assign any_tei_hit  = (|t_hit) | tei_grp;
   assign accept       = (|pair_ok) | (sapi_grp & ((|t_hit) | tei_grp));
endmodule

// File: rtl/lapd_af_seq.sv
module lapd_af_seq
   import lapd_af_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_valid,
   input  logic         rx_sof,
   input  logic         rx_eof,
   input  logic [W-1:0] rx_data,
   input  logic         accept_in,
   output logic [W-1:0] sapi_oct,
   output logic         verdict_valid,
   output logic         verdict_accept
);
   af_state_e    state;
   logic [W-1:0] sapi_q;
   logic         start_b;

   assign start_b  = rx_valid & rx_sof;
   assign sapi_oct = sapi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= ST_IDLE;
         sapi_q         <= '0;
         verdict_valid  <= 1'b0;
         verdict_accept <= 1'b0;
      end else begin
         verdict_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_b) begin
                  sapi_q <= rx_data;
                  if (rx_eof) begin
                     verdict_valid  <= 1'b1;
                     verdict_accept <= 1'b0;
                  end else begin
                     state <= ST_WANT_TEI;
                  end
               end
            end
            ST_WANT_TEI: begin
               if (start_b) begin
                  sapi_q <= rx_data;
                  if (rx_eof) begin
                     verdict_valid  <= 1'b1;
                     verdict_accept <= 1'b0;
                     state          <= ST_IDLE;
                  end
               end else if (rx_valid) begin
                  verdict_valid  <= 1'b1;
                  verdict_accept <= accept_in;
                  state          <= ST_IDLE;
               end else if (rx_eof) begin
                  verdict_valid  <= 1'b1;
                  verdict_accept <= 1'b0;
                  state          <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_tei_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WANT_TEI && rx_valid && !rx_sof) |=> verdict_valid);

   p_short_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WANT_TEI && !rx_valid && rx_eof) |=> (verdict_valid && !verdict_accept));

   p_accept_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(verdict_accept) |-> verdict_valid);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start_b) |=> !verdict_valid);
endmodule

// File: rtl/lapd_addr_filter.sv
module lapd_addr_filter
   import lapd_af_pkg::*;
#(
   parameter int N_PAIRS = 2,
   localparam int CFG_AW = $clog2(2 * N_PAIRS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [7:0]        rx_data,
   output logic              verdict_valid,
   output logic              verdict_accept
);
   initial begin
      assert (N_PAIRS >= 1 && N_PAIRS <= 16)
         else $error("lapd_addr_filter: N_PAIRS out of range");
      assert (OCT_W == 8)
         else $error("lapd_addr_filter: octet width must be 8");
   end

   logic [N_PAIRS-1:0][OCT_W-1:0] sapi_ref, tei_ref;
   logic [OCT_W-1:0]              sapi_mask, tei_mask, sapi_oct;
   logic                          accept_c, any_s, any_t;

   lapd_af_regs #(.N_PAIRS(N_PAIRS), .W(OCT_W), .AW(CFG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .sapi_ref(sapi_ref), .tei_ref(tei_ref), .sapi_mask(sapi_mask), .tei_mask(tei_mask));

   lapd_af_decide #(.N_PAIRS(N_PAIRS), .W(OCT_W)) u_decide (
      .sapi_oct(sapi_oct), .tei_oct(rx_data), .sapi_ref(sapi_ref), .tei_ref(tei_ref),
      .sapi_mask(sapi_mask), .tei_mask(tei_mask),
      .any_sapi_hit(any_s), .any_tei_hit(any_t), .accept(accept_c));

   lapd_af_seq #(.W(OCT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_data(rx_data), .accept_in(accept_c), .sapi_oct(sapi_oct),
      .verdict_valid(verdict_valid), .verdict_accept(verdict_accept));

   // R3: an accepted frame needed a SAPI hit and a TEI hit in the deciding cycle
   p_accept_needs_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_valid && verdict_accept) |-> ($past(any_s) && $past(any_t)));
endmodule

// File: tb/lapd_addr_filter_bench.sv
module lapd_addr_filter_bench;
   localparam int NP = 2;
   localparam int AW = $clog2(2 * NP + 2);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0, rx_data = '0;
   logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic verdict_valid, verdict_accept;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;
   logic [7:0] m_sap [NP];
   logic [7:0] m_tei [NP];
   logic [7:0] m_sm, m_tm;

   always #4 clk = ~clk;

   lapd_addr_filter #(.N_PAIRS(NP)) u_lapd_addr_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
      .verdict_valid(verdict_valid), .verdict_accept(verdict_accept));

   function automatic bit exp_acc(logic [7:0] s, logic [7:0] t);
      bit sg = (s == 8'hFE) || (s == 8'hFC);
      bit tg = (t == 8'hFF);
      bit acc = sg && tg;
      for (int i = 0; i < NP; i++) begin
         bit si = ((s ^ m_sap[i]) & ~m_sm) == 8'h00;
         bit ti = ((t ^ m_tei[i]) & ~m_tm) == 8'h00;
         if (si && (ti || tg)) acc = 1'b1;
         if (sg && ti) acc = 1'b1;
      end
      return acc;
   endfunction

   task automatic check(string req, logic [1:0] got, logic [1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got valid/accept=%b expected %b", req, got, exp);
      end
   endtask

   task automatic wr(int idx, logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(idx); cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < NP) m_sap[idx] = v;
      else if (idx < 2*NP) m_tei[idx-NP] = v;
      else if (idx == 2*NP) m_sm = v;
      else if (idx == 2*NP+1) m_tm = v;
   endtask

   // frame of SAPI + TEI; sample one cycle after the TEI byte
   task automatic frame(string req, logic [7:0] s, logic [7:0] t);
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b1; rx_data = s;
      @(negedge clk);
      rx_sof = 1'b0; rx_data = t;
      @(negedge clk);
      rx_valid = 1'b0;
      check(req, {verdict_valid, verdict_accept}, {1'b1, exp_acc(s, t)});
   endtask

   initial begin : wd
      #(200000 * 8);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: got hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic prev;
      void'($urandom(32'h1A5D));
      for (int i = 0; i < NP; i++) begin m_sap[i] = 0; m_tei[i] = 0; end
      m_sm = 0; m_tm = 0;
      repeat (3) @(negedge clk);
      check("R10 reset", {verdict_valid, verdict_accept}, 2'b00);
      rst_n = 1'b1;
      // R1: reset registers are zero -> SAPI 0 / TEI 0 accepted
      frame("R1 reset regs", 8'h00, 8'h00);
      wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h42); wr(3, 8'h84);
      wr(6, 8'h55); // R1 unused index: no effect
      frame("R1 unused index", 8'h10, 8'h42);
      frame("R3 sap1+tei1", 8'h10, 8'h42);
      frame("R6 sap1+grp", 8'h10, 8'hFF);
      frame("R3 sap2+tei2", 8'h20, 8'h84);
      frame("R6 sap2+grp", 8'h20, 8'hFF);
      frame("R5 grpFE+tei1", 8'hFE, 8'h42);
      frame("R5 grpFC+tei2", 8'hFC, 8'h84);
      frame("R5 grp+grp", 8'hFE, 8'hFF);
      frame("R4 sap1+tei2", 8'h10, 8'h84);
      frame("R4 sap2+tei1", 8'h20, 8'h42);
      frame("R5 near group", 8'hFD, 8'h42);
      // R7: masks widen programmable compares
      wr(4, 8'h0C); wr(5, 8'h01);
      frame("R7 masked sapi", 8'h1C, 8'h43);
      frame("R7 unmasked bit", 8'h30, 8'h42);
      // R8: masks that would hide the group difference have no effect
      wr(4, 8'h03); wr(5, 8'h80);
      frame("R8 mask on grp sapi", 8'hFF, 8'h42);
      frame("R8 mask on grp tei", 8'h10, 8'h7F);
      frame("R8 sapi FA", 8'hFA, 8'hFF);
      wr(4, 8'h00); wr(5, 8'h00);
      // R9: start byte then end marker
      @(negedge clk); rx_valid = 1; rx_sof = 1; rx_data = 8'h10;
      @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 1;
      @(negedge clk); rx_eof = 0;
      check("R9 end before TEI", {verdict_valid, verdict_accept}, 2'b10);
      // R9: single-byte frame
      frame("R10 set accept", 8'h10, 8'h42);
      @(negedge clk); rx_valid = 1; rx_sof = 1; rx_eof = 1; rx_data = 8'hFE;
      @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
      check("R9 one byte frame", {verdict_valid, verdict_accept}, 2'b10);
      // R11: trailing bytes and bytes outside a frame give no strobe
      frame("R11 lead frame", 8'h20, 8'h84);
      prev = verdict_accept;
      @(negedge clk); rx_valid = 1; rx_data = 8'h10;
      @(negedge clk); rx_data = 8'h42;
      @(negedge clk); rx_valid = 0;
      check("R11 no strobe", {verdict_valid, verdict_accept}, {1'b0, prev});
      // R11: restart on a second start byte
      @(negedge clk); rx_valid = 1; rx_sof = 1; rx_data = 8'h33;
      @(negedge clk); rx_data = 8'h10;
      @(negedge clk); rx_sof = 0; rx_data = 8'h42;
      @(negedge clk); rx_valid = 0;
      check("R11 restart", {verdict_valid, verdict_accept}, 2'b11);
      // random frames against the model (R3..R8)
      for (int k = 0; k < 600; k++) begin
         logic [7:0] s, t;
         if (k % 60 == 0) begin
            for (int i = 0; i < 2*NP; i++) wr(i, 8'($urandom));
            wr(2*NP,   ($urandom % 3 == 0) ? 8'($urandom & $urandom) : 8'h00);
            wr(2*NP+1, ($urandom % 3 == 0) ? 8'($urandom & $urandom) : 8'h00);
         end
         case ($urandom % 5)
            0: s = m_sap[$urandom % NP];
            1: s = m_sap[$urandom % NP] ^ (8'h01 << ($urandom % 8));
            2: s = ($urandom % 2) ? 8'hFE : 8'hFC;
            3: s = 8'hFE ^ (8'h01 << ($urandom % 8));
            default: s = 8'($urandom);
         endcase
         case ($urandom % 5)
            0: t = m_tei[$urandom % NP];
            1: t = m_tei[$urandom % NP] ^ (8'h01 << ($urandom % 8));
            2: t = 8'hFF;
            3: t = 8'hFF ^ (8'h01 << ($urandom % 8));
            default: t = 8'($urandom);
         endcase
         frame("R3-pair random", s, t);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule